// File: doc/BRIEF.md
# Pin Event Flag Unit

This block watches a bank of asynchronous pin inputs. It brings each one into the clock domain through a two-stage synchronizer. It then turns edges or levels on the pin into a sticky status flag, one flag bit per pin. Each pin has its own 4-bit event code. The code chooses what kind of pin activity sets the flag. It also chooses whether that flag feeds the interrupt line, feeds the DMA request line, or feeds neither.

Software reads the flag vector and clears bits by writing ones to them. An acknowledge pulse from the DMA engine clears every flag that belongs to a DMA-coded pin, and leaves the other flags alone. A level-coded pin whose level is still active cannot be cleared: the condition sets the flag again in the same cycle.

Top module: `pin_event_flags`

## Requirements
- R1: While reset is held and after it is released with all codes 0, `flags_o` is all zero, and `irq_o` and `dma_req_o` are 0.
- R2: Code 0 never sets a flag. The unused codes 4, D, E and F also never set a flag.
- R3: Codes 1, 2 and 3 set the pin's flag on a rising edge, a falling edge and either edge respectively. `dma_req_o` is 1 whenever such a flag is set.
- R4: Codes 5, 6 and 7 set the flag on a rising edge, a falling edge and either edge respectively. These flags raise neither `irq_o` nor `dma_req_o`.
- R5: Codes 9, A and B set the flag on a rising edge, a falling edge and either edge respectively. `irq_o` is 1 while such a flag is set.
- R6: Code 8 sets the flag while the pin is 0, and code C sets it while the pin is 1. Both raise `irq_o`. A write-one clear has no effect while the level still holds.
- R7: When `w1c_en` is 1, every flag whose `w1c_data` bit is 1 clears on the next clock. Flags whose bit is 0 keep their value.
- R8: A `dma_ack` pulse clears the flags of pins coded 1 to 3. It does not clear any other flag.
- R9: If a set event and a clear reach the same flag in the same cycle, the flag ends up set.
- R10: A pin change applied before clock edge k shows in `flags_o` after edge k+2, and not before.
- R11: Bit i of `flags_o` belongs to pin i. For example, events on pins 0 and 16 alone give 0x00010001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset. Its release is synchronized internally. |
| pin_in | input | 32 | Asynchronous pin levels |
| cfg_in | input | 128 | Event code per pin. Pin i uses bits [4i+3:4i]. |
| w1c_en | input | 1 | Strobe for a write-one-to-clear operation |
| w1c_data | input | 32 | Mask of flags to clear |
| dma_ack | input | 1 | Pulse marking the end of a DMA transfer |
| flags_o | output | 32 | Sticky status flags, one per pin |
| irq_o | output | 1 | OR of the flags on interrupt-coded pins (8 to C) |
| dma_req_o | output | 1 | OR of the flags on DMA-coded pins (1 to 3) |

## Verification
Two functions can land in the same cycle. One is a detected pin event that sets a flag. The other is a clear of that same flag, from software or from the DMA acknowledge. The bench triggers the overlap in two ways. First, it times a write-one strobe into exactly the cycle in which a falling edge on an either-edge pin reaches the flag. Second, it holds an active level on a level-coded pin while clearing. In both cases the flag must read 1 afterwards. A second clear, made alone once the event has passed, must read 0. That proves the first clear was overruled and not ignored.

// File: rtl/pev_pkg.sv
package pev_pkg;

  localparam int CODE_W = 4;

  localparam logic [CODE_W-1:0] EV_OFF      = 4'h0;
  localparam logic [CODE_W-1:0] EV_DMA_RISE = 4'h1;
  localparam logic [CODE_W-1:0] EV_DMA_FALL = 4'h2;
  localparam logic [CODE_W-1:0] EV_DMA_BOTH = 4'h3;
  localparam logic [CODE_W-1:0] EV_FLG_RISE = 4'h5;
  localparam logic [CODE_W-1:0] EV_FLG_FALL = 4'h6;
  localparam logic [CODE_W-1:0] EV_FLG_BOTH = 4'h7;
  localparam logic [CODE_W-1:0] EV_IRQ_LOW  = 4'h8;
  localparam logic [CODE_W-1:0] EV_IRQ_RISE = 4'h9;
  localparam logic [CODE_W-1:0] EV_IRQ_FALL = 4'hA;
  localparam logic [CODE_W-1:0] EV_IRQ_BOTH = 4'hB;
  localparam logic [CODE_W-1:0] EV_IRQ_HIGH = 4'hC;

  typedef struct packed {
    logic on_rise;
    logic on_fall;
    logic on_low;
    logic on_high;
    logic to_dma;
    logic to_irq;
  } ev_dec_t;

  function automatic ev_dec_t ev_decode(input logic [CODE_W-1:0] code);
    ev_dec_t d;
    d = '0;
    case (code)
      EV_DMA_RISE: begin d.on_rise = 1'b1; d.to_dma = 1'b1; end
      EV_DMA_FALL: begin d.on_fall = 1'b1; d.to_dma = 1'b1; end
      EV_DMA_BOTH: begin d.on_rise = 1'b1; d.on_fall = 1'b1; d.to_dma = 1'b1; end
      EV_FLG_RISE: d.on_rise = 1'b1;
      EV_FLG_FALL: d.on_fall = 1'b1;
      EV_FLG_BOTH: begin d.on_rise = 1'b1; d.on_fall = 1'b1; end
      EV_IRQ_LOW:  begin d.on_low = 1'b1; d.to_irq = 1'b1; end
      EV_IRQ_RISE: begin d.on_rise = 1'b1; d.to_irq = 1'b1; end
      EV_IRQ_FALL: begin d.on_fall = 1'b1; d.to_irq = 1'b1; end
      EV_IRQ_BOTH: begin d.on_rise = 1'b1; d.on_fall = 1'b1; d.to_irq = 1'b1; end
      EV_IRQ_HIGH: begin d.on_high = 1'b1; d.to_irq = 1'b1; end
      default:     d = '0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/pev_sync.sv
module pev_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] cur_q,
  output logic [WIDTH-1:0] prev_q
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] meta_d, cur_d, prev_d;

  always_comb begin
    meta_d = async_in;
    cur_d  = meta_q;
    prev_d = cur_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= meta_d;
      cur_q  <= cur_d;
      prev_q <= prev_d;
    end
  end

endmodule

// File: rtl/pev_detect.sv
module pev_detect
  import pev_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic [NPINS-1:0]        cur,
  input  logic [NPINS-1:0]        prev,
  input  logic [NPINS*CODE_W-1:0] cfg,
  output logic [NPINS-1:0]        set_vec,
  output logic [NPINS-1:0]        dma_cls,
  output logic [NPINS-1:0]        irq_cls,
  output logic [NPINS-1:0]        off_cls
);

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    ev_dec_t dec;
    logic    rise, fall;

    always_comb begin
      dec  = ev_decode(cfg[i*CODE_W +: CODE_W]);
      rise = cur[i] & ~prev[i];
      fall = ~cur[i] & prev[i];
      set_vec[i] = (dec.on_rise & rise) | (dec.on_fall & fall) |
                   (dec.on_low & ~cur[i]) | (dec.on_high & cur[i]);
      dma_cls[i] = dec.to_dma;
      irq_cls[i] = dec.to_irq;
      off_cls[i] = ~(dec.on_rise | dec.on_fall | dec.on_low | dec.on_high);
    end
  end

endmodule

// File: rtl/pev_flags.sv
module pev_flags #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] set_vec,
  input  logic             w1c_en,
  input  logic [NPINS-1:0] w1c_data,
  input  logic             dma_ack,
  input  logic [NPINS-1:0] dma_cls,
  output logic [NPINS-1:0] flags_q
);

  logic [NPINS-1:0] clr_vec;
  logic [NPINS-1:0] flags_d;

  always_comb begin
    clr_vec = (w1c_en ? w1c_data : '0) | (dma_ack ? dma_cls : '0);
    // Set is applied after clear so it takes priority.
    flags_d = (flags_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((flags_q & $past(set_vec)) == $past(set_vec)));

  assert_w1c_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    w1c_en |=> ((flags_q & $past(w1c_data & ~set_vec)) == '0));

  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dma_ack |=> ((flags_q & $past(dma_cls & ~set_vec)) == '0));

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~flags_q & $past(flags_q) & ~$past(clr_vec)) == '0));

endmodule

// File: rtl/pin_event_flags.sv
module pin_event_flags
  import pev_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPINS-1:0]        pin_in,
  input  logic [NPINS*CODE_W-1:0] cfg_in,
  input  logic                    w1c_en,
  input  logic [NPINS-1:0]        w1c_data,
  input  logic                    dma_ack,
  output logic [NPINS-1:0]        flags_o,
  output logic                    irq_o,
  output logic                    dma_req_o
);

  logic [1:0]       rst_pipe_q;
  logic             rst_int_n;
  logic [NPINS-1:0] cur, prev, set_vec, dma_cls, irq_cls, off_cls;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  pev_sync #(.WIDTH(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .async_in(pin_in),
    .cur_q(cur), .prev_q(prev)
  );

  pev_detect #(.NPINS(NPINS)) u_detect (
    .cur(cur), .prev(prev), .cfg(cfg_in),
    .set_vec(set_vec), .dma_cls(dma_cls), .irq_cls(irq_cls), .off_cls(off_cls)
  );

  pev_flags #(.NPINS(NPINS)) u_flags (
    .clk(clk), .rst_n(rst_int_n), .set_vec(set_vec),
    .w1c_en(w1c_en), .w1c_data(w1c_data),
    .dma_ack(dma_ack), .dma_cls(dma_cls), .flags_q(flags_o)
  );

  always_comb begin
    irq_o     = |(flags_o & irq_cls);
    dma_req_o = |(flags_o & dma_cls);
  end

  assert_irq_has_flag_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq_o |-> (flags_o != '0));

  assert_dma_has_flag_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    dma_req_o |-> (flags_o != '0));

  assert_off_never_sets_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    1'b1 |=> ((flags_o & ~$past(flags_o) & $past(off_cls)) == '0));

  assert_reset_clean_R1: assert property (@(posedge clk)
    !rst_int_n |-> (flags_o == '0 && !irq_o && !dma_req_o));

endmodule

// File: tb/pin_event_flags_bench.sv
module pin_event_flags_bench;

  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  pin_in;
  logic [N*4-1:0] cfg_in;
  logic          w1c_en;
  logic [N-1:0]  w1c_data;
  logic          dma_ack;
  logic [N-1:0]  flags_o;
  logic          irq_o, dma_req_o;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  pin_event_flags u_pin_event_flags (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cfg_in(cfg_in),
    .w1c_en(w1c_en), .w1c_data(w1c_data), .dma_ack(dma_ack),
    .flags_o(flags_o), .irq_o(irq_o), .dma_req_o(dma_req_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_code(input int pin, input logic [3:0] code);
    cfg_in[pin*4 +: 4] = code;
  endtask

  task automatic clear_all();
    cfg_in = '0; pin_in = '0;
    edges(3);
    w1c_en = 1'b1; w1c_data = '1;
    edges(1);
    w1c_en = 1'b0; w1c_data = '0;
  endtask

  task automatic pulse_w1c(input logic [31:0] mask);
    w1c_en = 1'b1; w1c_data = mask;
    edges(1);
    w1c_en = 1'b0; w1c_data = '0;
  endtask

  task automatic t_reset();
    chk("R1 flags in reset", flags_o, 0);
    chk("R1 irq/dma in reset", {30'd0, irq_o, dma_req_o}, 0);
  endtask

  task automatic t_after_reset();
    edges(4);
    chk("R1 flags after release", flags_o, 0);
    chk("R1 irq/dma after release", {30'd0, irq_o, dma_req_o}, 0);
  endtask

  task automatic t_disabled();
    clear_all();
    set_code(0, 4'h0); set_code(1, 4'h4); set_code(2, 4'hD);
    set_code(3, 4'hE); set_code(4, 4'hF);
    pin_in[4:0] = 5'h1F; edges(4);
    pin_in[4:0] = 5'h00; edges(4);
    chk("R2 off/unused codes set nothing", flags_o, 0);
  endtask

  task automatic t_dma();
    clear_all();
    set_code(2, 4'h1); set_code(3, 4'h2); set_code(4, 4'h3);
    pin_in[2] = 1'b1; pin_in[3] = 1'b1; pin_in[4] = 1'b1;
    edges(2);
    chk("R10 not yet after two edges", flags_o, 0);
    edges(1);
    chk("R3 rise sets codes 1 and 3 (R10 timing)", flags_o, 32'h14);
    chk("R3 dma_req raised", {31'd0, dma_req_o}, 1);
    chk("R3 no irq for dma codes", {31'd0, irq_o}, 0);
    dma_ack = 1'b1; edges(1); dma_ack = 1'b0;
    chk("R8 ack clears dma flags", flags_o, 0);
    chk("R8 dma_req drops", {31'd0, dma_req_o}, 0);
    pin_in[2] = 1'b0; pin_in[3] = 1'b0; pin_in[4] = 1'b0;
    edges(3);
    chk("R3 fall sets codes 2 and 3 only", flags_o, 32'h18);
  endtask

  task automatic t_flag_only();
    clear_all();
    set_code(0, 4'h5); set_code(16, 4'h5); set_code(5, 4'h6); set_code(6, 4'h7);
    pin_in[0] = 1'b1; pin_in[16] = 1'b1;
    edges(3);
    chk("R11 pins 0 and 16 map to bits 0 and 16", flags_o, 32'h00010001);
    chk("R4 no irq/dma", {30'd0, irq_o, dma_req_o}, 0);
    pulse_w1c('1);
    pin_in[5] = 1'b1; pin_in[6] = 1'b1; edges(3);
    chk("R4 rise: only code 7", flags_o, 32'h40);
    pulse_w1c('1);
    pin_in[5] = 1'b0; pin_in[6] = 1'b0; edges(3);
    chk("R4 fall: codes 6 and 7", flags_o, 32'h60);
    chk("R4 no irq/dma after fall", {30'd0, irq_o, dma_req_o}, 0);
  endtask

  task automatic t_edge_irq();
    clear_all();
    set_code(8, 4'h9); set_code(9, 4'hA); set_code(10, 4'hB);
    pin_in[10:8] = 3'b111; edges(3);
    chk("R5 rise: codes 9 and B", flags_o, 32'h500);
    chk("R5 irq raised", {31'd0, irq_o}, 1);
    pulse_w1c(32'h100);
    chk("R7 clear bit 8 only", flags_o, 32'h400);
    pulse_w1c(32'h0);
    chk("R7 zero mask keeps flags", flags_o, 32'h400);
    pulse_w1c(32'h400);
    pin_in[10:8] = 3'b000; edges(3);
    chk("R5 fall: codes A and B", flags_o, 32'h600);
  endtask

  task automatic t_level();
    clear_all();
    set_code(12, 4'hC);
    pin_in[12] = 1'b1; edges(3);
    chk("R6 high level sets", flags_o, 32'h1000);
    chk("R6 irq raised", {31'd0, irq_o}, 1);
    pulse_w1c(32'h1000);
    chk("R6 clear overruled while high", flags_o, 32'h1000);
    pin_in[12] = 1'b0; edges(3);
    pulse_w1c(32'h1000);
    chk("R6 clear works once low", flags_o, 0);
    set_code(13, 4'h8);
    edges(1);
    chk("R6 low level sets code 8", flags_o, 32'h2000);
  endtask

  task automatic t_ack_selective();
    clear_all();
    set_code(4, 4'h1); set_code(6, 4'h9); set_code(7, 4'h5);
    pin_in[4] = 1'b1; pin_in[6] = 1'b1; pin_in[7] = 1'b1; edges(3);
    chk("R8 setup", flags_o, 32'hD0);
    dma_ack = 1'b1; edges(1); dma_ack = 1'b0;
    chk("R8 ack keeps non-dma flags", flags_o, 32'hC0);
  endtask

  task automatic t_collision();
    clear_all();
    set_code(7, 4'hB);
    pin_in[7] = 1'b1; edges(3);
    chk("R9 setup", flags_o, 32'h80);
    pin_in[7] = 1'b0;
    edges(2);
    w1c_en = 1'b1; w1c_data = 32'h80;
    edges(1);
    w1c_en = 1'b0; w1c_data = '0;
    chk("R9 set beats same-cycle clear", flags_o, 32'h80);
    pulse_w1c(32'h80);
    chk("R9 lone clear afterwards", flags_o, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pin_in = '0; cfg_in = '0;
    w1c_en = 1'b0; w1c_data = '0; dma_ack = 1'b0;
    edges(3);
    t_reset();
    rst_n = 1'b1;
    t_after_reset();
    t_disabled();
    t_dma();
    t_flag_only();
    t_edge_irq();
    t_level();
    t_ack_selective();
    t_collision();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule